// File: doc/BRIEF.md
# Relative Branch Resolution Unit

This block resolves short relative branches for a small 8-bit processor core. The fetch stage hands it the opcode byte of a two-byte branch, the signed 8-bit displacement byte that follows it, and the address the opcode was fetched from. It also receives the zero and carry condition flags. From these it decides whether control transfers and what the program counter becomes next.

The displacement counts from the first byte after the two-byte instruction. A displacement of zero therefore falls through to the next instruction, and a displacement of -2 loops back onto the branch itself. A branch-to-subroutine is always taken. For it, the block raises a call flag and presents the link address, so the stack logic elsewhere can save it. An opcode outside the supported set is reported as illegal and never transfers control. The negative and overflow flags are not consulted by any supported opcode, so they are not ports.

All results are registered and appear on the clock edge that follows the cycle in which the request strobe was high.

Top module: `branch_resolve`

## Requirements
- R1: While reset is asserted and after it is released, before any request, out_valid_o, taken_o, call_o and illegal_o are 0, and next_pc_o and ret_addr_o are 0.
- R2: out_valid_o is 1 in exactly the cycle after a cycle with valid_i high, and 0 after a cycle with valid_i low.
- R3: Opcode 0x20 is always taken, with next_pc_o = pc_i + 2 + sign-extended displacement, modulo 2^16.
- R4: Opcode 0x22 is taken only when flag_c_i and flag_z_i are both 0.
- R5: Opcode 0x24 is taken only when flag_c_i is 0.
- R6: Opcode 0x27 is taken only when flag_z_i is 1.
- R7: When a request is not taken, next_pc_o equals pc_i + 2.
- R8: Opcode 0x8D is always taken with the same target rule as R3, sets call_o to 1, and sets ret_addr_o to pc_i + 2. call_o is 0 for every other opcode.
- R9: A displacement of 0x00 gives a target of pc_i + 2, a displacement of 0xFE gives a target of pc_i, and targets wrap around modulo 2^16 in both directions.
- R10: Any opcode other than 0x20, 0x22, 0x24, 0x27 or 0x8D sets illegal_o to 1 and drives taken_o and call_o to 0. illegal_o is 0 for the supported opcodes.
- R11: In a cycle with valid_i low, taken_o, next_pc_o, call_o, ret_addr_o and illegal_o keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe for one branch |
| opcode_i | input | 8 | Branch opcode byte |
| disp_i | input | 8 | Signed displacement byte |
| pc_i | input | 16 | Address of the opcode byte |
| flag_z_i | input | 1 | Zero condition flag |
| flag_c_i | input | 1 | Carry condition flag |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| taken_o | output | 1 | Branch transfers control |
| next_pc_o | output | 16 | Program counter after the branch |
| call_o | output | 1 | Subroutine call, link address must be saved |
| ret_addr_o | output | 16 | Link address, opcode address plus two |
| illegal_o | output | 1 | Opcode not in the supported set |

## Verification
On every cycle, the assertions check the timing of the result strobe and that results hold between requests. They also check that a call is always taken and never illegal, that an illegal opcode never transfers control, that a fall-through PC equals the link address, and the flag tests for the carry-clear and equal opcodes. The target arithmetic can only be shown by the bench's scenarios: forward and backward offsets, the self-loop and fall-through offsets, and wrap-around at both ends of the address space. The same holds for the four flag combinations of the higher test and for the choice of rejected opcodes.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int PC_W       = 16,
  parameter int DISP_W     = 8,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  output logic              out_valid_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              call_o,
  output logic [PC_W-1:0]   ret_addr_o,
  output logic              illegal_o
);

  localparam logic [7:0] OP_ALWAYS = 8'h20;
  localparam logic [7:0] OP_HIGHER = 8'h22;
  localparam logic [7:0] OP_NOCARRY = 8'h24;
  localparam logic [7:0] OP_EQUAL = 8'h27;
  localparam logic [7:0] OP_CALL = 8'h8D;
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] seq_pc, tgt_pc;
  logic            go, is_call, bad;

  assign seq_pc = pc_i + PC_W'(INSN_BYTES);
  assign tgt_pc = seq_pc + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    go      = 1'b0;
    is_call = 1'b0;
    bad     = 1'b0;
    case (opcode_i)
      OP_ALWAYS:  go = 1'b1;
      OP_HIGHER:  go = ~(flag_c_i | flag_z_i);
      OP_NOCARRY: go = ~flag_c_i;
      OP_EQUAL:   go = flag_z_i;
      OP_CALL: begin
        go      = 1'b1;
        is_call = 1'b1;
      end
      default:    bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      next_pc_o   <= '0;
      call_o      <= 1'b0;
      ret_addr_o  <= '0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= valid_i;
      if (valid_i) begin
        taken_o    <= go;
        next_pc_o  <= go ? tgt_pc : seq_pc;
        call_o     <= is_call;
        ret_addr_o <= seq_pc;
        illegal_o  <= bad;
      end
    end
  end

endmodule

module branch_resolve_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [7:0]      opcode_i,
  input logic            flag_z_i,
  input logic            flag_c_i,
  input logic            out_valid_o,
  input logic            taken_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            call_o,
  input logic [PC_W-1:0] ret_addr_o,
  input logic            illegal_o
);

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> out_valid_o);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !out_valid_o);

  a_r5_carry_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && opcode_i == 8'h24 && flag_c_i) |=> !taken_o);

  a_r6_equal_follows_z: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && opcode_i == 8'h27) |=> (taken_o == $past(flag_z_i)));

  a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !taken_o) |-> (next_pc_o == ret_addr_o));

  a_r8_call_taken: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> (taken_o && !illegal_o));

  a_r10_illegal_inert: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!taken_o && !call_o));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(taken_o) && $stable(next_pc_o) && $stable(call_o)
                  && $stable(ret_addr_o) && $stable(illegal_o)));

endmodule

bind branch_resolve branch_resolve_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
  .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .out_valid_o(out_valid_o),
  .taken_o(taken_o), .next_pc_o(next_pc_o), .call_o(call_o),
  .ret_addr_o(ret_addr_o), .illegal_o(illegal_o)
);

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  disp_i = '0;
  logic [15:0] pc_i = '0;
  logic        flag_z_i = 1'b0;
  logic        flag_c_i = 1'b0;
  logic        out_valid_o, taken_o, call_o, illegal_o;
  logic [15:0] next_pc_o, ret_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  branch_resolve dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
    .disp_i(disp_i), .pc_i(pc_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i),
    .out_valid_o(out_valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .call_o(call_o), .ret_addr_o(ret_addr_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] d, input logic [15:0] pc,
                       input logic z, input logic c, input string req);
    logic        e_take, e_call, e_bad;
    logic [15:0] e_seq, e_tgt;
    e_seq  = pc + 16'd2;
    e_tgt  = e_seq + {{8{d[7]}}, d};
    e_call = (op == 8'h8D);
    e_bad  = !(op inside {8'h20, 8'h22, 8'h24, 8'h27, 8'h8D});
    case (op)
      8'h20, 8'h8D: e_take = 1'b1;
      8'h22: e_take = (c == 1'b0) && (z == 1'b0);
      8'h24: e_take = (c == 1'b0);
      8'h27: e_take = (z == 1'b1);
      default: e_take = 1'b0;
    endcase
    @(negedge clk);
    valid_i = 1'b1; opcode_i = op; disp_i = d; pc_i = pc; flag_z_i = z; flag_c_i = c;
    @(posedge clk); #1;
    chk({req, " R2 valid"}, 32'(out_valid_o), 32'd1);
    chk({req, " taken"}, 32'(taken_o), 32'(e_take));
    chk({req, " next_pc"}, 32'(next_pc_o), 32'(e_take ? e_tgt : e_seq));
    chk({req, " R8 call"}, 32'(call_o), 32'(e_call));
    chk({req, " R8 ret_addr"}, 32'(ret_addr_o), 32'(e_seq));
    chk({req, " R10 illegal"}, 32'(illegal_o), 32'(e_bad));
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 out_valid", 32'(out_valid_o), 32'd0);
    chk("R1 taken", 32'(taken_o), 32'd0);
    chk("R1 call", 32'(call_o), 32'd0);
    chk("R1 illegal", 32'(illegal_o), 32'd0);
    chk("R1 next_pc", 32'(next_pc_o), 32'd0);
    chk("R1 ret_addr", 32'(ret_addr_o), 32'd0);
  endtask

  task automatic t_always;
    issue(8'h20, 8'h00, 16'h1000, 1'b1, 1'b1, "R3 fwd0");
    issue(8'h20, 8'hFC, 16'h1000, 1'b0, 1'b0, "R3 back");
    issue(8'h20, 8'h7F, 16'h2000, 1'b0, 1'b1, "R3 maxfwd");
  endtask

  task automatic t_higher;
    for (int k = 0; k < 4; k++)
      issue(8'h22, 8'h10, 16'h3000, k[1], k[0], "R4 higher");
  endtask

  task automatic t_nocarry;
    issue(8'h24, 8'h04, 16'h4000, 1'b1, 1'b0, "R5 c0");
    issue(8'h24, 8'h04, 16'h4000, 1'b0, 1'b1, "R5 c1 R7");
  endtask

  task automatic t_equal;
    issue(8'h27, 8'hF0, 16'h5000, 1'b1, 1'b1, "R6 z1");
    issue(8'h27, 8'hF0, 16'h5000, 1'b0, 1'b0, "R6 z0 R7");
  endtask

  task automatic t_call;
    issue(8'h8D, 8'hF7, 16'h6010, 1'b0, 1'b1, "R8 call");
  endtask

  task automatic t_edges;
    issue(8'h27, 8'hFE, 16'h7000, 1'b1, 1'b0, "R9 selfloop");
    issue(8'h20, 8'h00, 16'h7100, 1'b0, 1'b0, "R9 zero");
    issue(8'h20, 8'h7F, 16'hFFFF, 1'b0, 1'b0, "R9 wrap up");
    issue(8'h20, 8'h80, 16'h0000, 1'b0, 1'b0, "R9 wrap down");
  endtask

  task automatic t_illegal;
    issue(8'h21, 8'h10, 16'h8000, 1'b1, 1'b0, "R10 op21");
    issue(8'h18, 8'h10, 16'h8000, 1'b0, 1'b0, "R10 op18");
    issue(8'hBD, 8'h10, 16'h8000, 1'b1, 1'b1, "R10 opBD");
  endtask

  task automatic t_hold;
    issue(8'h8D, 8'h20, 16'h9000, 1'b0, 1'b0, "R11 setup");
    @(negedge clk);
    opcode_i = 8'h21; disp_i = 8'h80; pc_i = 16'hAAAA; flag_z_i = 1'b1; flag_c_i = 1'b1;
    @(posedge clk); #1;
    chk("R11 R2 out_valid low", 32'(out_valid_o), 32'd0);
    chk("R11 taken", 32'(taken_o), 32'd1);
    chk("R11 next_pc", 32'(next_pc_o), 32'h9022);
    chk("R11 call", 32'(call_o), 32'd1);
    chk("R11 ret_addr", 32'(ret_addr_o), 32'h9002);
    chk("R11 illegal", 32'(illegal_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", 32'(out_valid_o), 32'd0);
    t_always;
    t_higher;
    t_nocarry;
    t_equal;
    t_call;
    t_edges;
    t_illegal;
    t_hold;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule